// File: doc/BRIEF.md
# Sector Load and Program Sequencer

This block is the write-side controller of a byte-wide nonvolatile memory that is reprogrammed one whole sector at a time. The chip-enable, write-enable and output-enable strobes arrive asynchronously. They are brought into the system clock domain, and a write is recognised from them. The first write of a load freezes the sector number. Every write, the first one included, places a byte into a staging buffer at the in-sector offset it names. The offsets may come in any order. Once no further byte arrives within a fixed number of clock cycles after the previous one, loading stops. A timed program phase then copies the whole sector into the storage array. During that copy, each byte that was not loaded is replaced by FFh.

While the program phase runs, the block signals busy in two forms. One output is the enable of a pull-down on a shared wired ready line. The other is the logic level that the line would show. A read path returns stored bytes, so the committed contents can be observed. An active-low reset cancels a load or a program phase that is in progress.

Top module: `sector_prog_seq`

## Requirements
- R1: While reset is low, and right after it is released, busy_pull_o is 0, ready_o is 1 and dout_en_o is 0.
- R2: A write is recognised only while ce_n_i and we_n_i are both 0 and oe_n_i is 1. A strobe with oe_n_i held at 0 loads nothing and starts no program phase.
- R3: The byte offset is taken when the write becomes active, which is the falling edge of whichever of ce_n_i or we_n_i falls last. The data byte is taken when the write ends, which is the rising edge of whichever rises first. Changes on addr_i or din_i between those two points have no effect.
- R4: addr_i bits [SEC_W-1:0] select the sector and bits [SEC_W+BYTE_W-1:SEC_W] select the byte within it. The sector bits are taken at the first write of a load, and the sector bits of every later write in that load are ignored.
- R5: Bytes of a sector may be loaded in any order. Each loaded byte is committed at its own offset.
- R6: After a program phase, every byte of the sector that was not loaded in that load reads FFh.
- R7: The program phase begins LOAD_TO clock cycles after the last byte is captured. busy_pull_o stays 1, and ready_o stays 0, for exactly PROG_CYCLES cycles.
- R8: The program phase writes only the latched sector. Bytes of other sectors keep their values.
- R9: Write strobes that occur during the program phase are ignored.
- R10: Reset low during a load or a program phase aborts it. An aborted load commits nothing, and ready_o is 1 as soon as reset goes low.
- R11: While ce_n_i and oe_n_i are 0 and we_n_i is 1, dout_en_o is 1 and dout_o carries the stored byte at addr_i. With oe_n_i at 1, dout_en_o is 0.
- R12: Each new load starts with no byte marked as loaded. A byte loaded in an earlier load but not in the current one reads FFh after the current program phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset and abort |
| ce_n_i | input | 1 | Chip enable strobe, active low, asynchronous |
| we_n_i | input | 1 | Write enable strobe, active low, asynchronous |
| oe_n_i | input | 1 | Output enable strobe, active low, asynchronous |
| addr_i | input | SEC_W+BYTE_W | Sector bits in the low part, byte offset in the high part |
| din_i | input | 8 | Write data |
| dout_o | output | 8 | Read data |
| dout_en_o | output | 1 | Read data is being driven |
| busy_pull_o | output | 1 | Enable of the pull-down on the shared ready line during programming |
| ready_o | output | 1 | Level of the ready line: 0 while programming |

Parameter constraint: PROG_CYCLES must be at least 2**BYTE_W, because the copy writes one byte per cycle.

## Verification
An edge on the strobe pins takes effect at the third rising clock edge after it, because of the two synchroniser stages and the edge-detect register. Read data and dout_en_o therefore settle three edges after the read strobes. busy_pull_o rises LOAD_TO edges after the data capture of the last byte and falls PROG_CYCLES edges after that. The bench drives every input on falling edges and samples on falling edges. For the program phase it counts rising edges from the end of the last write to the busy transition and compares the count with the number derived from LOAD_TO. It then counts the length of the busy interval and compares it with PROG_CYCLES. Data checks wait at least five cycles after a strobe before sampling.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_PROG = 2'd2
    } phase_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic [STAGES-1:0] chain_d;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign sync_o[i] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/sector_buffer.sv
module sector_buffer #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              we_i,
    input  logic [BYTE_W-1:0] waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [BYTE_W-1:0] raddr_i,
    output logic [7:0]        rdata_o
);
    import seq_pkg::*;

    localparam int DEPTH = 1 << BYTE_W;

    logic [7:0]       data_q [DEPTH];
    logic [DEPTH-1:0] flags_q;
    logic [DEPTH-1:0] flags_d;

    always_comb begin
        flags_d = flags_q;
        if (clr_i)     flags_d = '0;
        else if (we_i) flags_d[waddr_i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    always_ff @(posedge clk) begin
        if (we_i && !clr_i) data_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = flags_q[raddr_i] ? data_q[raddr_i] : ERASED_BYTE;

    assert_flags_cleared_R12: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (flags_q == '0));
endmodule

// File: rtl/sector_array.sv
module sector_array #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic          re_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];
    logic [7:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
        if (re_i) rdata_q <= mem_q[raddr_i];
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/sector_prog_seq.sv
module sector_prog_seq #(
    parameter int SEC_W       = 3,
    parameter int BYTE_W      = 8,
    parameter int LOAD_TO     = 16,
    parameter int PROG_CYCLES = 300
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce_n_i,
    input  logic                    we_n_i,
    input  logic                    oe_n_i,
    input  logic [SEC_W+BYTE_W-1:0] addr_i,
    input  logic [7:0]              din_i,
    output logic [7:0]              dout_o,
    output logic                    dout_en_o,
    output logic                    busy_pull_o,
    output logic                    ready_o
);
    import seq_pkg::*;

    localparam int ADDR_W       = SEC_W + BYTE_W;
    localparam int SECTOR_BYTES = 1 << BYTE_W;
    localparam int TMR_W        = $clog2(LOAD_TO + 1);
    localparam int PC_W         = $clog2(PROG_CYCLES + 1);

    typedef struct packed {
        phase_e            phase;
        logic [SEC_W-1:0]  sector;
        logic [BYTE_W-1:0] byte_sel;
        logic [TMR_W-1:0]  timer;
        logic [PC_W-1:0]   pcount;
        logic              active;
        logic              rd_en;
    } st_t;

    st_t st_q, st_d;

    logic [2:0] strobes_s;
    logic       ce_s, we_s, oe_s;
    logic       active_now, wr_start, wr_end, rd_now;
    logic       buf_we, buf_clr, mem_we;
    logic [7:0] buf_rdata;
    logic [7:0] mem_rdata;

    strobe_sync #(.N(3), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({oe_n_i, we_n_i, ce_n_i}),
        .sync_o  (strobes_s)
    );

    assign ce_s = strobes_s[0];
    assign we_s = strobes_s[1];
    assign oe_s = strobes_s[2];

    assign active_now = !ce_s && !we_s && oe_s;
    assign wr_start   = active_now && !st_q.active;
    assign wr_end     = !active_now && st_q.active;
    assign rd_now     = !ce_s && !oe_s && we_s;

    always_comb begin
        st_d        = st_q;
        st_d.active = active_now;
        st_d.rd_en  = rd_now;
        buf_we      = 1'b0;
        buf_clr     = 1'b0;
        mem_we      = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (wr_start) begin
                    st_d.phase    = PH_LOAD;
                    st_d.sector   = addr_i[SEC_W-1:0];
                    st_d.byte_sel = addr_i[ADDR_W-1:SEC_W];
                    st_d.timer    = '0;
                    buf_clr       = 1'b1;
                end
            end
            PH_LOAD: begin
                if (wr_start) begin
                    st_d.byte_sel = addr_i[ADDR_W-1:SEC_W];
                    st_d.timer    = '0;
                end else if (wr_end) begin
                    buf_we     = 1'b1;
                    st_d.timer = '0;
                end else if (st_q.active) begin
                    st_d.timer = st_q.timer;
                end else if (st_q.timer == TMR_W'(LOAD_TO - 1)) begin
                    st_d.phase  = PH_PROG;
                    st_d.pcount = '0;
                end else begin
                    st_d.timer = st_q.timer + 1'b1;
                end
            end
            PH_PROG: begin
                mem_we = (32'(st_q.pcount) < SECTOR_BYTES);
                if (st_q.pcount == PC_W'(PROG_CYCLES - 1)) begin
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.pcount = st_q.pcount + 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, sector: '0, byte_sel: '0, timer: '0,
                      pcount: '0, active: 1'b0, rd_en: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    sector_buffer #(.BYTE_W(BYTE_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (buf_clr),
        .we_i    (buf_we),
        .waddr_i (st_q.byte_sel),
        .wdata_i (din_i),
        .raddr_i (st_q.pcount[BYTE_W-1:0]),
        .rdata_o (buf_rdata)
    );

    sector_array #(.AW(ADDR_W)) u_array (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i ({st_q.sector, st_q.pcount[BYTE_W-1:0]}),
        .wdata_i (buf_rdata),
        .re_i    (rd_now),
        .raddr_i ({addr_i[SEC_W-1:0], addr_i[ADDR_W-1:SEC_W]}),
        .rdata_o (mem_rdata)
    );

    assign dout_o      = mem_rdata;
    assign dout_en_o   = st_q.rd_en;
    assign busy_pull_o = (st_q.phase == PH_PROG);
    assign ready_o     = (st_q.phase != PH_PROG);

    assert_prog_after_timeout_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_PROG && $past(st_q.phase) != PH_PROG)
            |-> ($past(st_q.phase) == PH_LOAD && $past(st_q.timer) == TMR_W'(LOAD_TO - 1)));

    assert_prog_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_PROG) |-> (32'(st_q.pcount) < PROG_CYCLES));

    assert_sector_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_LOAD && $past(st_q.phase) == PH_LOAD) |-> $stable(st_q.sector));

    assert_no_load_in_prog_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_PROG) |-> (!buf_we && !buf_clr));

    assert_array_write_in_prog_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (st_q.phase == PH_PROG));

    assert_busy_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy_pull_o |-> !ready_o);
endmodule

// File: tb/tb_sector_prog_seq.sv
`timescale 1ns/1ps
module tb_sector_prog_seq;
    localparam int SEC_W   = 2;
    localparam int BYTE_W  = 4;
    localparam int LOAD_TO = 20;
    localparam int PROG    = 40;
    localparam int AW      = SEC_W + BYTE_W;

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [BYTE_W-1:0] byt;
        logic [7:0]        dat;
    } vec_t;

    // R5: scrambled load order into sector 2
    localparam vec_t LOADV [4] = '{
        '{sec: 2'd2, byt: 4'd3,  dat: 8'hAA},
        '{sec: 2'd2, byt: 4'd0,  dat: 8'h11},
        '{sec: 2'd2, byt: 4'd15, dat: 8'h5E},
        '{sec: 2'd2, byt: 4'd7,  dat: 8'hC3}
    };
    // expected contents after program (R5, R6)
    localparam vec_t CHKV [6] = '{
        '{sec: 2'd2, byt: 4'd0,  dat: 8'h11},
        '{sec: 2'd2, byt: 4'd3,  dat: 8'hAA},
        '{sec: 2'd2, byt: 4'd7,  dat: 8'hC3},
        '{sec: 2'd2, byt: 4'd15, dat: 8'h5E},
        '{sec: 2'd2, byt: 4'd1,  dat: 8'hFF},
        '{sec: 2'd2, byt: 4'd8,  dat: 8'hFF}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          dout_en, busy_pull, ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    sector_prog_seq #(.SEC_W(SEC_W), .BYTE_W(BYTE_W), .LOAD_TO(LOAD_TO), .PROG_CYCLES(PROG)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n), .we_n_i(we_n), .oe_n_i(oe_n),
        .addr_i(addr), .din_i(din), .dout_o(dout), .dout_en_o(dout_en),
        .busy_pull_o(busy_pull), .ready_o(ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] mk(input logic [SEC_W-1:0] s, input logic [BYTE_W-1:0] b);
        return {b, s};
    endfunction

    task automatic wr(input logic [SEC_W-1:0] s, input logic [BYTE_W-1:0] b,
                      input logic [7:0] d, input bit ce_ctrl);
        @(negedge clk);
        addr = mk(s, b);
        din  = d;
        if (ce_ctrl) begin
            we_n = 1'b0; @(negedge clk); ce_n = 1'b0;
        end else begin
            ce_n = 1'b0; @(negedge clk); we_n = 1'b0;
        end
        repeat (4) @(negedge clk);
        if (ce_ctrl) ce_n = 1'b1; else we_n = 1'b1;
        repeat (4) @(negedge clk);
        ce_n = 1'b1;
        we_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic rd(input logic [SEC_W-1:0] s, input logic [BYTE_W-1:0] b,
                      output logic [7:0] d, output logic en);
        @(negedge clk);
        addr = mk(s, b);
        ce_n = 1'b0;
        oe_n = 1'b0;
        repeat (5) @(negedge clk);
        d  = dout;
        en = dout_en;
        oe_n = 1'b1;
        ce_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input logic [SEC_W-1:0] s,
                          input logic [BYTE_W-1:0] b, input logic [7:0] exp);
        logic [7:0] d;
        logic en;
        rd(s, b, d, en);
        chk(req, {24'd0, d}, {24'd0, exp});
    endtask

    task automatic wait_level(input logic lvl, output int cnt);
        cnt = 0;
        for (int i = 0; i < 2000; i++) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (ready == lvl) break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        logic [7:0] d;
        logic en;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 busy_pull in reset", {31'd0, busy_pull}, 0);
        chk("R1 ready in reset", {31'd0, ready}, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 dout_en after reset", {31'd0, dout_en}, 0);
        chk("R1 ready after reset", {31'd0, ready}, 1);

        // Table-driven load (R5), timing (R7), contents (R6)
        foreach (LOADV[i]) wr(LOADV[i].sec, LOADV[i].byt, LOADV[i].dat, 1'b0);
        wait_level(1'b0, n);
        chk("R7 load timeout cycles", n, LOAD_TO - 3);
        wait_level(1'b1, n);
        chk("R7 program cycles", n, PROG);
        foreach (CHKV[i]) rd_chk(CHKV[i].dat == 8'hFF ? "R6 unloaded byte" : "R5 loaded byte",
                                 CHKV[i].sec, CHKV[i].byt, CHKV[i].dat);

        // Second load into sector 1: R3, R4, R9
        wr(2'd1, 4'd5, 8'h42, 1'b0);
        wr(2'd3, 4'd9, 8'h99, 1'b0);            // R4: sector bits ignored
        @(negedge clk);                          // R3: address and data change mid-strobe
        addr = mk(2'd1, 4'd2);
        din  = 8'h10;
        ce_n = 1'b0; @(negedge clk); we_n = 1'b0;
        repeat (4) @(negedge clk);
        addr = mk(2'd1, 4'd12);
        din  = 8'h27;
        repeat (4) @(negedge clk);
        we_n = 1'b1;
        repeat (4) @(negedge clk);
        ce_n = 1'b1;
        repeat (2) @(negedge clk);
        wr(2'd1, 4'd6, 8'h66, 1'b1);            // R3: CE-controlled write
        wait_level(1'b0, n);
        wr(2'd2, 4'd1, 8'h00, 1'b0);            // R9: strobe during program
        wait_level(1'b1, n);
        repeat (LOAD_TO + 10) @(negedge clk);
        chk("R9 no second program", {31'd0, ready}, 1);
        rd_chk("R4 later sector bits ignored", 2'd1, 4'd9, 8'h99);
        rd_chk("R5 first byte", 2'd1, 4'd5, 8'h42);
        rd_chk("R3 data at strobe end", 2'd1, 4'd2, 8'h27);
        rd_chk("R3 late address ignored", 2'd1, 4'd12, 8'hFF);
        rd_chk("R3 CE-controlled write", 2'd1, 4'd6, 8'h66);
        rd_chk("R8 other sector kept", 2'd2, 4'd3, 8'hAA);
        rd_chk("R9 write during program ignored", 2'd2, 4'd1, 8'hFF);

        // R12: new load clears loaded flags
        wr(2'd2, 4'd0, 8'h77, 1'b0);
        wait_level(1'b0, n);
        wait_level(1'b1, n);
        rd_chk("R12 new byte", 2'd2, 4'd0, 8'h77);
        rd_chk("R12 earlier byte erased", 2'd2, 4'd3, 8'hFF);

        // R2: OE low inhibits write
        @(negedge clk);
        addr = mk(2'd2, 4'd0);
        din  = 8'h01;
        oe_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b0;
        we_n = 1'b0;
        repeat (5) @(negedge clk);
        we_n = 1'b1;
        ce_n = 1'b1;
        @(negedge clk);
        oe_n = 1'b1;
        repeat (LOAD_TO + 10) @(negedge clk);
        chk("R2 no program with OE low", {31'd0, ready}, 1);
        rd_chk("R2 byte unchanged", 2'd2, 4'd0, 8'h77);

        // R10: reset during load
        wr(2'd2, 4'd0, 8'h55, 1'b0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        for (int i = 0; i < LOAD_TO + PROG; i++) begin
            @(negedge clk);
            if (!ready) n++;
        end
        chk("R10 aborted load never busy", n, 0);
        rd_chk("R10 aborted load commits nothing", 2'd2, 4'd0, 8'h77);

        // R10: reset during program
        wr(2'd0, 4'd0, 8'h12, 1'b0);
        wait_level(1'b0, n);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R10 ready on reset in program", {31'd0, ready}, 1);
        chk("R10 pull released", {31'd0, busy_pull}, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (PROG) @(negedge clk);
        chk("R10 stays ready after abort", {31'd0, ready}, 1);

        // R11: read enable qualification
        rd(2'd1, 4'd5, d, en);
        chk("R11 dout_en on read", {31'd0, en}, 1);
        chk("R11 read data", {24'd0, d}, 32'h42);
        @(negedge clk);
        ce_n = 1'b0;
        repeat (5) @(negedge clk);
        chk("R11 no drive with OE high", {31'd0, dout_en}, 0);
        ce_n = 1'b1;
        repeat (3) @(negedge clk);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule